// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter, four bits wide by default, that can be preset from a parallel data word. All count bits are held in one register that updates on the rising clock edge. A low on the load input copies the data word into the count at the next edge. The counter advances only when two separate enables are both high; otherwise it holds its value. The second of these enables, the chain enable, also gates a terminal-carry output. That output is high while the count is all ones and the chain enable is high.

Wider counters are built by chaining stages. Every stage shares the clock, the clear, the load and the count enable. The carry output of each stage drives the chain enable of the next stage, so no extra gating is needed. The carry is formed combinationally, so the next stage sees it in the same cycle.

A parameter picks the clear style. In asynchronous style, a low clear forces zero at once. In synchronous style, a low clear gives zero at the next edge. Feeding a decode of some count value back into a synchronous clear shortens the count cycle.

Top module: `presettable_counter`

## Requirements
- R1: With CLR_MODE = CLR_ASYNC, driving `clr_n` low forces `q` to zero at once, with no clock edge needed. `q` stays zero at every edge while `clr_n` is low, whatever `load_n`, the enables and `din` are.
- R2: With CLR_MODE = CLR_SYNC, a low `clr_n` sampled at a rising edge makes `q` zero after that edge. This takes priority over a low `load_n` and over both enables.
- R3: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din` after that edge. This holds whatever the enables are, so load beats counting.
- R4: When `clr_n` and `load_n` are both high at an edge, `q` goes up by one only if `cnt_en` and `chain_en` are both high. If either enable is low, `q` keeps its value.
- R5: Incrementing from all ones (4'b1111 at the default width) gives all zeros.
- R6: `carry_out` is 1 exactly when `chain_en` is 1 and `q` is all ones. It follows `q` and `chain_en` in the same cycle, and `cnt_en` has no effect on it.
- R7: Two stages can be chained: the low stage's `carry_out` drives the high stage's `chain_en`, and both stages share `cnt_en`, `load_n` and `clr_n`. The pair then counts as one synchronous counter of twice the width. It wraps from 255 to 0, and its top carry is high at 255.
- R8: In synchronous clear style, a decode of count value N-1 can drive `clr_n`. The counter then cycles 0, 1, …, N-1, 0, and never reaches N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous depending on CLR_MODE |
| load_n | input | 1 | Active-low synchronous parallel preset |
| din | input | WIDTH | Preset data word |
| cnt_en | input | 1 | Count enable; affects counting only |
| chain_en | input | 1 | Count enable that also gates the terminal carry |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal carry: chain_en and count all ones |

## Verification
Load, increment, hold, wrap and synchronous clear all show on `q` one rising edge after the inputs are sampled. The carry output and the asynchronous clear act within the same cycle, with no edge. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It compares `q` and the carry 2 ns after each rising edge. Asynchronous clear is checked 1 ns after `clr_n` falls, between edges.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic {
    CLR_ASYNC = 1'b0,
    CLR_SYNC  = 1'b1
  } clr_mode_e;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INC   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    sync_clr_n,
  input  logic    load_n,
  input  logic    cnt_en,
  input  logic    chain_en,
  output cnt_op_e op
);

  // Fixed priority at each edge: clear, load, increment, hold.
  always_comb begin
    if (!sync_clr_n)             op = OP_CLEAR;
    else if (!load_n)            op = OP_LOAD;
    else if (cnt_en && chain_en) op = OP_INC;
    else                         op = OP_HOLD;
  end

endmodule

// File: rtl/cnt_reg.sv
module cnt_reg
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             async_clr_n,
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] nxt;

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_INC:   nxt = q + WIDTH'(1);
      default:  nxt = q;
    endcase
  end

  // All bits share one edge; the async clear is tied high in sync mode.
  always_ff @(posedge clk or negedge async_clr_n) begin
    if (!async_clr_n) q <= '0;
    else              q <= nxt;
  end

endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             chain_en,
  output logic             carry_out
);

  localparam logic [WIDTH-1:0] TERM = '1;

  assign carry_out = chain_en && (q == TERM);

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import cnt_pkg::*;
#(
  parameter int        WIDTH    = 4,
  parameter clr_mode_e CLR_MODE = CLR_SYNC
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             cnt_en,
  input  logic             chain_en,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);

  logic    sync_clr_n;
  logic    async_clr_n;
  cnt_op_e op;

  generate
    if (CLR_MODE == CLR_SYNC) begin : g_sync_clr
      assign sync_clr_n  = clr_n;
      assign async_clr_n = 1'b1;
    end else begin : g_async_clr
      assign sync_clr_n  = 1'b1;
      assign async_clr_n = clr_n;
    end
  endgenerate

  cnt_ctrl u_ctrl (
    .sync_clr_n (sync_clr_n),
    .load_n     (load_n),
    .cnt_en     (cnt_en),
    .chain_en   (chain_en),
    .op         (op)
  );

  cnt_reg #(.WIDTH(WIDTH)) u_reg (
    .clk         (clk),
    .async_clr_n (async_clr_n),
    .op          (op),
    .din         (din),
    .q           (q)
  );

  cnt_carry #(.WIDTH(WIDTH)) u_carry (
    .q         (q),
    .chain_en  (chain_en),
    .carry_out (carry_out)
  );

endmodule

// File: rtl/presettable_counter_chk.sv
module presettable_counter_chk
  import cnt_pkg::*;
#(
  parameter int        WIDTH    = 4,
  parameter clr_mode_e CLR_MODE = CLR_SYNC
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic             cnt_en,
  input logic             chain_en,
  input logic [WIDTH-1:0] q,
  input logic             carry_out
);

  localparam logic [WIDTH-1:0] ALL1 = '1;

  p_load_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (!load_n) |=> (q == $past(din)));

  p_inc_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en && chain_en) |=> (q == WIDTH'($past(q) + 1'b1)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(cnt_en && chain_en)) |=> $stable(q));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en && chain_en && q == ALL1) |=> (q == '0));

  p_carry_gate_r6: assert property (@(posedge clk)
    (!chain_en) |-> (!carry_out));

  p_carry_tc_r6: assert property (@(posedge clk)
    carry_out |-> (q == ALL1));

  generate
    if (CLR_MODE == CLR_SYNC) begin : g_sync
      p_sync_clear_r2: assert property (@(posedge clk)
        (!clr_n) |=> (q == '0));
    end else begin : g_async
      p_async_clear_r1: assert property (@(posedge clk)
        (!clr_n) |-> (q == '0));
    end
  endgenerate

endmodule

bind presettable_counter presettable_counter_chk #(
  .WIDTH    (WIDTH),
  .CLR_MODE (CLR_MODE)
) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .din       (din),
  .cnt_en    (cnt_en),
  .chain_en  (chain_en),
  .q         (q),
  .carry_out (carry_out)
);

// File: tb/sim_presettable_counter.sv
`timescale 1ns/1ps
module sim_presettable_counter;
  import cnt_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // single stage, synchronous clear
  logic s_clr_n = 0, s_load_n = 1, s_p = 0, s_t = 0;
  logic [3:0] s_d = '0;
  logic [3:0] s_q;
  logic s_co;
  presettable_counter #(.WIDTH(4), .CLR_MODE(CLR_SYNC)) u0 (
    .clk(clk), .clr_n(s_clr_n), .load_n(s_load_n), .din(s_d),
    .cnt_en(s_p), .chain_en(s_t), .q(s_q), .carry_out(s_co));

  // two chained stages, synchronous clear, optional truncation decode
  logic c_clr_ext_n = 0, c_load_n = 1, c_p = 0, c_t = 0;
  logic [7:0] c_d = '0;
  logic trunc_en = 0;
  logic [7:0] trunc_top = 8'd9;
  logic [3:0] c_qlo, c_qhi;
  logic c_co_lo, c_co_hi;
  logic [7:0] c_q;
  logic c_clr_n;
  assign c_q     = {c_qhi, c_qlo};
  assign c_clr_n = c_clr_ext_n && !(trunc_en && c_q == trunc_top);

  presettable_counter #(.WIDTH(4), .CLR_MODE(CLR_SYNC)) u1 (
    .clk(clk), .clr_n(c_clr_n), .load_n(c_load_n), .din(c_d[3:0]),
    .cnt_en(c_p), .chain_en(c_t), .q(c_qlo), .carry_out(c_co_lo));
  presettable_counter #(.WIDTH(4), .CLR_MODE(CLR_SYNC)) u2 (
    .clk(clk), .clr_n(c_clr_n), .load_n(c_load_n), .din(c_d[7:4]),
    .cnt_en(c_p), .chain_en(c_co_lo), .q(c_qhi), .carry_out(c_co_hi));

  // single stage, asynchronous clear
  logic a_clr_n = 0, a_load_n = 1, a_p = 0, a_t = 0;
  logic [3:0] a_d = '0;
  logic [3:0] a_q;
  logic a_co;
  presettable_counter #(.WIDTH(4), .CLR_MODE(CLR_ASYNC)) u3 (
    .clk(clk), .clr_n(a_clr_n), .load_n(a_load_n), .din(a_d),
    .cnt_en(a_p), .chain_en(a_t), .q(a_q), .carry_out(a_co));

  // behavioural reference models
  int m_s = 0, m_c = 0, m_a = 0;

  always @(negedge a_clr_n) m_a = 0;

  always @(posedge clk) begin
    if (!s_clr_n)          m_s = 0;
    else if (!s_load_n)    m_s = int'(s_d);
    else if (s_p && s_t)   m_s = (m_s + 1) % 16;

    if (!c_clr_ext_n || (trunc_en && m_c == int'(trunc_top))) m_c = 0;
    else if (!c_load_n)  m_c = int'(c_d);
    else if (c_p && c_t) m_c = (m_c + 1) % 256;

    if (!a_clr_n)        m_a = 0;
    else if (!a_load_n)  m_a = int'(a_d);
    else if (a_p && a_t) m_a = (m_a + 1) % 16;

    #2;
    if (!done) begin
      check("R2 R3 R4 R5 u0 q", int'(s_q), m_s);
      check("R6 u0 carry", int'(s_co), int'(s_t && m_s == 15));
      check("R7 R8 chain q", int'(c_q), m_c);
      check("R7 chain carry", int'(c_co_hi), int'(c_t && m_c == 255));
      check("R1 R3 R4 u3 q", int'(a_q), m_a);
      check("R6 u3 carry", int'(a_co), int'(a_t && m_a == 15));
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    cyc(2);
    // reset state
    check("R2 reset u0", int'(s_q), 0);
    check("R1 reset u3", int'(a_q), 0);
    s_clr_n = 1; c_clr_ext_n = 1; a_clr_n = 1;

    // u0: count through a wrap (R4, R5)
    s_p = 1; s_t = 1; cyc(20);
    // hold with each enable low (R4)
    s_p = 0; cyc(3);
    s_p = 1; s_t = 0; cyc(3);
    // load ignores enables (R3)
    s_load_n = 0; s_d = 4'd14; s_p = 0; s_t = 0; cyc(1);
    s_load_n = 1; cyc(1);
    check("R3 load without enables", int'(s_q), 14);
    s_p = 1; s_t = 1; cyc(1);
    // at 15 with cnt_en low: carry still high (R6)
    s_p = 0; cyc(1);
    check("R6 carry at terminal count", int'(s_co), 1);
    s_t = 0; #1;
    check("R6 carry gated by chain_en", int'(s_co), 0);
    cyc(1);
    // load with enables high beats counting (R3)
    s_p = 1; s_t = 1; s_load_n = 0; s_d = 4'd5; cyc(2);
    s_load_n = 1; cyc(1);
    // clear beats load and enables (R2)
    s_clr_n = 0; s_load_n = 0; s_d = 4'd9; cyc(1);
    check("R2 sync clear over load", int'(s_q), 0);
    s_clr_n = 1; s_load_n = 1; cyc(4);
    // clr low mid-cycle has no effect before the edge (R2)
    s_clr_n = 0; #1;
    check("R2 no clear before edge", int'(s_q), 4);
    cyc(1); s_clr_n = 1;

    // chain: wide counting with wrap (R7)
    c_p = 1; c_t = 1; cyc(300);
    c_load_n = 0; c_d = 8'hFE; cyc(1);
    c_load_n = 1; cyc(1);
    check("R7 chain at 255", int'(c_q), 255);
    check("R7 chain top carry", int'(c_co_hi), 1);
    cyc(1);
    check("R7 chain wrap", int'(c_q), 0);
    c_load_n = 0; c_d = 8'h0F; c_t = 0; cyc(1);
    c_load_n = 1; cyc(3);
    check("R7 chain hold", int'(c_q), 15);
    // truncated count 0..9 (R8)
    c_clr_ext_n = 0; cyc(1);
    c_clr_ext_n = 1; trunc_en = 1; c_t = 1; cyc(9);
    check("R8 truncated top", int'(c_q), 9);
    cyc(1);
    check("R8 truncated wrap", int'(c_q), 0);
    cyc(35);

    // async stage (R1)
    a_p = 1; a_t = 1; cyc(7);
    a_clr_n = 0; #1;
    check("R1 async clear immediate", int'(a_q), 0);
    a_load_n = 0; a_d = 4'd11; cyc(2);
    check("R1 clear holds over load", int'(a_q), 0);
    a_clr_n = 1; cyc(1);
    check("R3 async stage load", int'(a_q), 11);
    a_load_n = 1; cyc(6);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule